// File: doc/BRIEF.md
# Unique Line-Address History Ring

This block keeps a short, shared record of which cache lines the data side of a core has touched recently, across all load instructions. Each incoming access presents a byte address and a hit/miss flag. The block drops the byte offset inside a 64-byte line to form a line frame number. It appends that frame to a circular store only when no valid entry already holds it, so repeated touches of the same line do not crowd out older history.

Once all slots are in use, the slot holding the oldest frame is reused. The miss flag is kept with each entry, so a downstream pattern detector can look at all accesses or at misses only. Each fresh insertion raises a one-cycle trigger that tells the detector the history has grown.

The detector walks the history through a registered read port addressed by age, where 0 is the newest entry. An age that points past the filled part of the store reads back an entry marked not valid.

Top module: `line_history_ring`

## Requirements
- R1: The frame stored for an access is `acc_addr[ADDR_W-1:LINE_SHIFT]` (bits 31:6 by default). Two addresses that differ only in bits 5:0 name the same line.
- R2: An access whose frame matches any valid entry is dropped. Nothing is written, the newest entry stays the same, `trig_o` stays low, and the stored miss flag of the matching entry is unchanged.
- R3: An access whose frame matches no valid entry is written as the new age-0 entry. `trig_o` is high in exactly the cycle after the strobe, for that one cycle only.
- R4: After reset, every age reads back `rd_info` = 2'b00 and `rd_frame` = 0.
- R5: With all 2^IDX_W (128) slots valid, the next unique insertion overwrites the oldest entry. Its frame is then absent and is accepted again as new, while the entry that was second oldest becomes age 2^IDX_W-1.
- R6: `rd_info[0]` is the miss flag given with the inserting access (1 = miss), and `rd_info[1]` is the entry-valid flag (1 = holds a frame).
- R7: The read port returns, one cycle after `rd_age` is presented, the entry that was at that age before any insertion made in the same cycle. Age 0 is the newest entry and age k is the entry inserted k unique insertions earlier.
- R8: A valid flag, once set, never clears except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_miss | input | 1 | 1 if the access missed the cache |
| trig_o | output | 1 | One-cycle pulse after a unique insertion |
| rd_age | input | IDX_W | Age to read, 0 = newest |
| rd_frame | output | ADDR_W-LINE_SHIFT | Frame stored at the requested age |
| rd_info | output | 2 | {valid, miss} of the requested age |

## Verification
The embedded assertions check four things on every cycle:
- the write pointer holds on a duplicate and steps by exactly one on each trigger;
- the trigger appears only after a strobe;
- valid flags never fall.

Only the bench scenarios can show what is actually stored and returned by age. That covers the frame reduction, the untouched miss flag of a matched entry, the empty state after reset, the overwrite of the oldest entry on the 129th unique line, and the read-before-write ordering.

// File: rtl/line_history_ring.sv
module line_history_ring #(
  parameter int ADDR_W     = 32,
  parameter int LINE_SHIFT = 6,
  parameter int IDX_W      = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_valid,
  input  logic [ADDR_W-1:0]            acc_addr,
  input  logic                         acc_miss,
  output logic                         trig_o,
  input  logic [IDX_W-1:0]             rd_age,
  output logic [ADDR_W-LINE_SHIFT-1:0] rd_frame,
  output logic [1:0]                   rd_info
);
  localparam int DEPTH   = 1 << IDX_W;
  localparam int FRAME_W = ADDR_W - LINE_SHIFT;

  logic [FRAME_W-1:0] frm [DEPTH];
  logic [DEPTH-1:0]   vld, mis;
  logic [IDX_W-1:0]   wr_ptr;
  logic               dup;

  wire [FRAME_W-1:0] in_frame = acc_addr[ADDR_W-1:LINE_SHIFT];
  wire               ins      = acc_valid && !dup;
  wire [IDX_W-1:0]   rd_slot  = wr_ptr - IDX_W'(1) - rd_age;

  logic unused_low;
  assign unused_low = ^acc_addr[LINE_SHIFT-1:0];

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && frm[i] == in_frame) dup = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      vld      <= '0;
      mis      <= '0;
      trig_o   <= 1'b0;
      rd_frame <= '0;
      rd_info  <= '0;
      for (int i = 0; i < DEPTH; i++) frm[i] <= '0;
    end else begin
      trig_o   <= ins;
      rd_frame <= frm[rd_slot];
      rd_info  <= {vld[rd_slot], mis[rd_slot]};
      if (ins) begin
        frm[wr_ptr] <= in_frame;
        vld[wr_ptr] <= 1'b1;
        mis[wr_ptr] <= acc_miss;
        wr_ptr      <= wr_ptr + IDX_W'(1);
      end
    end
  end

  assert_dup_holds_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && dup) |=> (wr_ptr == $past(wr_ptr)));

  assert_trig_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !trig_o);

  assert_trig_steps_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (wr_ptr == $past(wr_ptr) + IDX_W'(1)));

  assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(vld) & ~vld) == '0));
endmodule

// File: tb/tb_line_history_ring.sv
`timescale 1ns/1ps
module tb_line_history_ring;
  logic        clk = 0, rst_n = 0;
  logic        acc_valid = 0, acc_miss = 0;
  logic [31:0] acc_addr = '0;
  logic [6:0]  rd_age = '0;
  logic        trig_o;
  logic [25:0] rd_frame;
  logic [1:0]  rd_info;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  line_history_ring dut (.clk, .rst_n, .acc_valid, .acc_addr, .acc_miss,
                         .trig_o, .rd_age, .rd_frame, .rd_info);

  function automatic logic [25:0] fr(int k);
    return 26'(k * 37 + 5);
  endfunction
  function automatic logic ms(int k);
    return k[0] ^ k[2];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present one access for one cycle; check the trigger in the following cycle
  task automatic access(int k, logic [5:0] off, logic m, logic exp_trig, string req);
    @(negedge clk);
    acc_valid = 1; acc_addr = {fr(k), off}; acc_miss = m;
    @(negedge clk);
    acc_valid = 0;
    chk(req, 32'(trig_o), 32'(exp_trig));
  endtask

  task automatic rd_check(int age, int k, string req);
    @(negedge clk);
    rd_age = 7'(age);
    @(negedge clk);
    chk({req, " frame"}, 32'(rd_frame), 32'(fr(k)));
    chk({req, " info"},  32'(rd_info),  {30'd0, 1'b1, ms(k)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R3 actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4: empty after reset
    for (int a = 0; a < 128; a++) begin
      @(negedge clk); rd_age = 7'(a);
      @(negedge clk);
      chk("R4 info", 32'(rd_info), 0);
      chk("R4 frame", 32'(rd_frame), 0);
    end
    // R3/R6: fill with 128 unique lines
    for (int k = 0; k < 128; k++) access(k, 6'(k), ms(k), 1, "R3 unique trig");
    @(negedge clk);
    chk("R3 one-cycle trig", 32'(trig_o), 0);
    for (int a = 0; a < 128; a++) rd_check(a, 127 - a, "R7 age sweep");
    // R1/R2: same lines, other offsets, flipped miss flag -> dropped
    for (int k = 0; k < 128; k++) access(k, 6'(63 - k), !ms(k), 0, "R2/R1 dup no trig");
    rd_check(0, 127, "R2 newest kept");
    rd_check(5, 122, "R2 miss flag kept");
    rd_check(127, 0, "R2 oldest kept");
    // R5: 129th unique overwrites oldest
    access(128, 6'd9, ms(128), 1, "R5 129th trig");
    rd_check(0, 128, "R5 newest");
    rd_check(127, 1, "R5 second oldest now last");
    access(0, 6'd0, ms(0), 1, "R5 evicted frame is new again");
    rd_check(0, 0, "R5 reinserted");
    rd_check(1, 128, "R5 age1");
    rd_check(127, 2, "R5 age127");
    access(2, 6'd1, 0, 0, "R2 still held");
    // R7: read sees pre-write state in the insertion cycle
    @(negedge clk);
    rd_age = 0; acc_valid = 1; acc_addr = {fr(129), 6'd3}; acc_miss = ms(129);
    @(negedge clk);
    acc_valid = 0;
    chk("R7 trig", 32'(trig_o), 1);
    chk("R7 read before write", 32'(rd_frame), 32'(fr(0)));
    @(negedge clk);
    chk("R7 read after write", 32'(rd_frame), 32'(fr(129)));
    chk("R6 info", 32'(rd_info), {30'd0, 1'b1, ms(129)});
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule